// File: doc/BRIEF.md
# Linked Page Chain Table Initializer

This block is a hardware sequencer that fills the next-pointer table of a paged packet buffer after reset. The table is split at a programmable boundary into two regions. Below the boundary the pages form a linear free list whose last page holds an end marker. From the boundary up to the last page the pages form a circular ring whose top entry points back to the boundary page.

Software or a boot controller sets the boundary, the last-entry index and a poll limit, then pulses start. The sequencer walks the table from address 0 upward and writes exactly one entry at a time through a command/status port. Each command is a single word that carries the address, the data and a write operation code. After each command the sequencer polls the status field until the table memory reports idle. If the memory stays active past the poll limit, the whole run stops at once. The block then reports the failing address and the region (phase) it was writing.

The boundary must lie between 1 and the last-entry index, inclusive. The last-entry index is normally 255 for a full 8-bit table. Run-time allocation and freeing of pages are not part of this block.

Top module: `pgchain_init`

## Requirements
- R1: A write is issued as a one-cycle `cmd_wr_o` pulse. `cmd_word_o` carries the entry address in bits [7:0], the entry data in bits [15:8] and the operation code in bits [17:16]. Write is 2'b01 and idle is 2'b00.
- R2: Only one write is ever outstanding. No new `cmd_wr_o` is issued until `stat_op_i` has been sampled at idle (2'b00) for the current write.
- R3: Every address a with a < boundary-1 is written with a+1.
- R4: Address boundary-1 is written with 8'hFF, the end-of-list marker.
- R5: Every address a with boundary <= a < last is written with a+1.
- R6: Address last is written with the boundary value, which closes the ring.
- R7: Writes are issued in strictly ascending address order, starting at 0. Every address from 0 to last is written exactly once, so a run makes last+1 writes.
- R8: A write completes on the first status sample that reads idle. A write whose status reads active on exactly poll-limit samples still completes.
- R9: If the status reads active on more than poll-limit samples, the run aborts. `err_o` rises, `err_addr_o` holds the failing address and `err_phase_o` holds the region code: 0 linear, 1 terminator, 2 ring, 3 closure. No further command is issued.
- R10: `busy_o` is high from the cycle after an accepted start until the run ends. `done_o` rises after the final write completes. `done_o` or `err_o` then holds until the next accepted start. The two are never high together, and neither is high while busy.
- R11: A start pulse while busy is ignored. The running configuration and the resulting table are unchanged.
- R12: After reset `busy_o`, `done_o`, `err_o` and `cmd_wr_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| boundary_i | input | AW | First ring page; the linear list ends at boundary-1 |
| last_i | input | AW | Index of the last table entry |
| poll_limit_i | input | PLW | Largest number of active status samples tolerated per write |
| cmd_wr_o | output | 1 | One-cycle write command strobe |
| cmd_word_o | output | AW+DW+2 | Packed command {op, data, address} |
| stat_op_i | input | 2 | Operation-status field read back from the table memory |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run finished without error |
| err_o | output | 1 | Last run aborted on a poll timeout |
| err_addr_o | output | AW | Address of the failing write |
| err_phase_o | output | 2 | Region of the failing write |

## Verification
Completion and timeout can be decided in the same poll sample. This happens when the memory stays active for exactly the poll-limit number of samples and shows idle on the sample where the counter reaches the limit. The bench provokes this by setting the slave latency equal to the poll limit, and expects the write to complete and the run to reach done. With a latency of one more than the limit, it expects an abort at a chosen address in each of the four regions. A second overlap is a start pulse arriving while a run is in flight. It is judged by checking that the finished table still matches the first configuration.

// File: rtl/pgchain_pkg.sv
// Shared encodings for the page chain initializer.
// Assumes a 2-bit operation field in the command word and in the status readback.
package pgchain_pkg;
    localparam int OPW = 2;
    localparam logic [OPW-1:0] OP_IDLE  = 2'b00;
    localparam logic [OPW-1:0] OP_WRITE = 2'b01;

    typedef enum logic [1:0] {
        PH_LINEAR = 2'd0,
        PH_TERM   = 2'd1,
        PH_RING   = 2'd2,
        PH_CLOSE  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_POLL  = 2'd2
    } state_e;
endpackage

// File: rtl/pgchain_entry_gen.sv
// Entry value generator: maps a table address to the value it must hold and
// the region it belongs to. Purely combinational.
// Assumes 1 <= bnd_i <= last_i and DW >= AW.
module pgchain_entry_gen
    import pgchain_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] bnd_i,
    input  logic [AW-1:0] last_i,
    output logic [DW-1:0] data_o,
    output phase_e        phase_o
);
    localparam logic [DW-1:0] END_MARK = {DW{1'b1}};

    logic [AW-1:0] list_tail;
    logic [AW-1:0] addr_next;

    assign list_tail = bnd_i - AW'(1);
    assign addr_next = addr_i + AW'(1);

    // Region decode and value selection for the current address.
    always_comb begin
        if (addr_i < list_tail) begin
            phase_o = PH_LINEAR;
            data_o  = DW'(addr_next);
        end else if (addr_i == list_tail) begin
            phase_o = PH_TERM;
            data_o  = END_MARK;
        end else if (addr_i < last_i) begin
            phase_o = PH_RING;
            data_o  = DW'(addr_next);
        end else begin
            phase_o = PH_CLOSE;
            data_o  = DW'(bnd_i);
        end
    end
endmodule

// File: rtl/pgchain_poll.sv
// Poll judge: counts the active status samples of the write in flight and
// decides, per sample, whether the write completed or timed out.
// Assumes clear_i pulses once per issued write, before the first sample.
module pgchain_poll
    import pgchain_pkg::*;
#(
    parameter int PLW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           sample_i,
    input  logic [OPW-1:0] stat_op_i,
    input  logic [PLW-1:0] limit_i,
    output logic           ok_o,
    output logic           timeout_o
);
    localparam logic [PLW-1:0] CNT_MAX = {PLW{1'b1}};

    logic           stat_idle;
    logic [PLW-1:0] busy_cnt;

    assign stat_idle = (stat_op_i == OP_IDLE);

    // Saturating count of active samples for the write in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (clear_i) begin
            busy_cnt <= '0;
        end else if (sample_i && !stat_idle && busy_cnt != CNT_MAX) begin
            busy_cnt <= busy_cnt + PLW'(1);
        end
    end

    // Per-sample verdict: an idle sample always wins over the limit.
    assign ok_o      = sample_i && stat_idle;
    assign timeout_o = sample_i && !stat_idle && (busy_cnt >= limit_i);

    // R8: a fresh write starts polling from a zero count
    p_cnt_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> busy_cnt == '0);
    // R8: never both completed and timed out
    p_verdict_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && timeout_o));
endmodule

// File: rtl/pgchain_ctrl.sv
// Run controller: accepts a start, walks the table addresses upward one write
// at a time, and ends the run on the final completion or on the first timeout.
// Assumes the poll judge produces at most one verdict per poll cycle.
module pgchain_ctrl
    import pgchain_pkg::*;
#(
    parameter int AW  = 8,
    parameter int PLW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [AW-1:0]  boundary_i,
    input  logic [AW-1:0]  last_i,
    input  logic [PLW-1:0] poll_limit_i,
    input  logic           poll_ok_i,
    input  logic           poll_to_i,
    input  phase_e         phase_i,
    output logic           accept_o,
    output logic           issue_o,
    output logic           polling_o,
    output logic           busy_o,
    output logic [AW-1:0]  addr_o,
    output logic [AW-1:0]  bnd_o,
    output logic [AW-1:0]  last_o,
    output logic [PLW-1:0] limit_o,
    output logic           done_o,
    output logic           err_o,
    output logic [AW-1:0]  err_addr_o,
    output logic [1:0]     err_phase_o
);
    state_e state_q;

    assign accept_o  = (state_q == ST_IDLE) && start_i;
    assign issue_o   = (state_q == ST_ISSUE);
    assign polling_o = (state_q == ST_POLL);
    assign busy_o    = (state_q != ST_IDLE);

    // Sequencing state, address walk and end-of-run flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            addr_o      <= '0;
            bnd_o       <= '0;
            last_o      <= '0;
            limit_o     <= '0;
            done_o      <= 1'b0;
            err_o       <= 1'b0;
            err_addr_o  <= '0;
            err_phase_o <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        bnd_o   <= boundary_i;
                        last_o  <= last_i;
                        limit_o <= poll_limit_i;
                        addr_o  <= '0;
                        done_o  <= 1'b0;
                        err_o   <= 1'b0;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_POLL;
                end
                ST_POLL: begin
                    if (poll_to_i) begin
                        err_o       <= 1'b1;
                        err_addr_o  <= addr_o;
                        err_phase_o <= phase_i;
                        state_q     <= ST_IDLE;
                    end else if (poll_ok_i) begin
                        if (addr_o == last_o) begin
                            done_o  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            addr_o  <= addr_o + AW'(1);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: a command strobe never lasts more than one cycle
    p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |=> !issue_o);
    // R11: a start seen while busy leaves the captured boundary alone
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(bnd_o));
    // R10: flags stay low while a run is in progress
    p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!done_o && !err_o));
endmodule

// File: rtl/pgchain_init.sv
// Page chain table initializer, top level. Packs each entry into a command
// word, issues it, polls the status field and reports done or the failing
// address and region. Assumes 1 <= boundary_i <= last_i and DW >= AW, and that
// the table memory shows a non-idle status from the cycle after each command
// until the write is complete.
module pgchain_init
    import pgchain_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 8,
    parameter int PLW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [AW-1:0]     boundary_i,
    input  logic [AW-1:0]     last_i,
    input  logic [PLW-1:0]    poll_limit_i,
    output logic              cmd_wr_o,
    output logic [AW+DW+1:0]  cmd_word_o,
    input  logic [1:0]        stat_op_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [AW-1:0]     err_addr_o,
    output logic [1:0]        err_phase_o
);
    logic           accept;
    logic           issue;
    logic           polling;
    logic           poll_ok;
    logic           poll_to;
    logic [AW-1:0]  cur_addr;
    logic [AW-1:0]  run_bnd;
    logic [AW-1:0]  run_last;
    logic [PLW-1:0] run_limit;
    logic [DW-1:0]  entry_data;
    phase_e         entry_phase;

    pgchain_ctrl #(.AW(AW), .PLW(PLW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .boundary_i  (boundary_i),
        .last_i      (last_i),
        .poll_limit_i(poll_limit_i),
        .poll_ok_i   (poll_ok),
        .poll_to_i   (poll_to),
        .phase_i     (entry_phase),
        .accept_o    (accept),
        .issue_o     (issue),
        .polling_o   (polling),
        .busy_o      (busy_o),
        .addr_o      (cur_addr),
        .bnd_o       (run_bnd),
        .last_o      (run_last),
        .limit_o     (run_limit),
        .done_o      (done_o),
        .err_o       (err_o),
        .err_addr_o  (err_addr_o),
        .err_phase_o (err_phase_o)
    );

    pgchain_entry_gen #(.AW(AW), .DW(DW)) u_gen (
        .addr_i (cur_addr),
        .bnd_i  (run_bnd),
        .last_i (run_last),
        .data_o (entry_data),
        .phase_o(entry_phase)
    );

    pgchain_poll #(.PLW(PLW)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (issue),
        .sample_i (polling),
        .stat_op_i(stat_op_i),
        .limit_i  (run_limit),
        .ok_o     (poll_ok),
        .timeout_o(poll_to)
    );

    // Command word packing: operation above data above address.
    assign cmd_wr_o   = issue;
    assign cmd_word_o = {OP_WRITE, entry_data, cur_addr};

    // Order tracker for the ascending-address check.
    logic [AW-1:0] prev_addr;
    logic          have_prev;
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            prev_addr <= '0;
            have_prev <= 1'b0;
        end else if (cmd_wr_o) begin
            prev_addr <= cmd_word_o[AW-1:0];
            have_prev <= 1'b1;
        end
    end

    // R7: the first write of a run targets address 0
    p_first_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_o && !have_prev) |-> cmd_word_o[AW-1:0] == '0);
    // R7: each later write targets the next address up
    p_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_o && have_prev) |-> cmd_word_o[AW-1:0] == prev_addr + AW'(1));
    // R4: the list tail carries the end marker
    p_term_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_o && cmd_word_o[AW-1:0] == run_bnd - AW'(1))
            |-> cmd_word_o[AW+DW-1:AW] == {DW{1'b1}});
    // R6: the top entry points back to the boundary page
    p_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_o && cmd_word_o[AW-1:0] == run_last)
            |-> cmd_word_o[AW+DW-1:AW] == DW'(run_bnd));
    // R9: nothing is issued once a run has aborted
    p_err_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !cmd_wr_o);
    // R10: done and error are exclusive
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));
endmodule

// File: tb/pgchain_init_bench.sv
`timescale 1ns/1ps
module pgchain_init_bench;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int PLW = 16;
    localparam int NONE = 9'h1FF;

    typedef struct packed {
        logic [7:0]  b;
        logic [7:0]  l;
        logic [15:0] lim;
        logic [7:0]  lat;
        logic [8:0]  fail;
    } vec_t;

    // boundary, last, poll limit, slave latency, failing address (1FF none)
    localparam vec_t VECS [8] = '{
        '{8'd8,   8'd15,  16'd4, 8'd2, 9'h1FF},
        '{8'd1,   8'd10,  16'd3, 8'd1, 9'h1FF},
        '{8'd10,  8'd10,  16'd3, 8'd3, 9'h1FF},
        '{8'd4,   8'd12,  16'd2, 8'd1, 9'd2},
        '{8'd4,   8'd12,  16'd2, 8'd2, 9'd3},
        '{8'd4,   8'd12,  16'd2, 8'd1, 9'd7},
        '{8'd4,   8'd12,  16'd2, 8'd2, 9'd12},
        '{8'd128, 8'd255, 16'd2, 8'd1, 9'h1FF}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [AW-1:0]     boundary_i = '0;
    logic [AW-1:0]     last_i = '0;
    logic [PLW-1:0]    poll_limit_i = '0;
    logic              cmd_wr_o;
    logic [AW+DW+1:0]  cmd_word_o;
    logic [1:0]        stat_op_i;
    logic              busy_o, done_o, err_o;
    logic [AW-1:0]     err_addr_o;
    logic [1:0]        err_phase_o;

    pgchain_init #(.AW(AW), .DW(DW), .PLW(PLW)) u_pgchain_init (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .boundary_i(boundary_i),
        .last_i(last_i), .poll_limit_i(poll_limit_i), .cmd_wr_o(cmd_wr_o),
        .cmd_word_o(cmd_word_o), .stat_op_i(stat_op_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .err_addr_o(err_addr_o),
        .err_phase_o(err_phase_o)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;

    // Table memory model with per-write latency.
    int         lat_norm = 1;
    int         lat_fail = 1;
    int         fail_at  = NONE;
    int         rem = 0;
    logic [7:0] pend_a, pend_d;
    logic [7:0] mem [256];
    logic       wrote [256];
    int         n_iss = 0;
    int         n_twice = 0;
    int         order_err = 0;
    int         op_err = 0;
    int         overlap_err = 0;
    int         exp_next = 0;

    assign stat_op_i = (rem != 0) ? 2'b01 : 2'b00;

    always @(posedge clk) begin
        if (!rst_n) begin
            rem <= 0;
        end else begin
            if (start_i && !busy_o) begin
                for (int i = 0; i < 256; i++) wrote[i] <= 1'b0;
                n_iss <= 0; n_twice <= 0; order_err <= 0; op_err <= 0;
                overlap_err <= 0; exp_next <= 0;
            end
            if (cmd_wr_o) begin
                if (rem != 0) overlap_err <= overlap_err + 1;
                if (cmd_word_o[17:16] != 2'b01) op_err <= op_err + 1;
                if (int'(cmd_word_o[7:0]) != exp_next) order_err <= order_err + 1;
                exp_next <= int'(cmd_word_o[7:0]) + 1;
                n_iss <= n_iss + 1;
                pend_a <= cmd_word_o[7:0];
                pend_d <= cmd_word_o[15:8];
                rem <= (int'(cmd_word_o[7:0]) == fail_at) ? lat_fail : lat_norm;
            end else if (rem != 0) begin
                rem <= rem - 1;
                if (rem == 1) begin
                    if (wrote[pend_a]) n_twice <= n_twice + 1;
                    mem[pend_a]   <= pend_d;
                    wrote[pend_a] <= 1'b1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_val(input int a, input int b, input int l);
        if (a == l) return 8'(b);
        if (a == b - 1) return 8'hFF;
        return 8'(a + 1);
    endfunction

    function automatic int exp_phase(input int a, input int b, input int l);
        if (a + 1 < b) return 0;
        if (a + 1 == b) return 1;
        if (a == l) return 3;
        return 2;
    endfunction

    task automatic kick(input int b, input int l, input int lim);
        @(negedge clk);
        boundary_i = 8'(b); last_i = 8'(l); poll_limit_i = 16'(lim);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 5000; i++) begin
            if (done_o || err_o) break;
            @(negedge clk);
        end
    endtask

    task automatic check_table(input int b, input int l, input int upto);
        int bad3 = 0, bad4 = 0, bad5 = 0, bad6 = 0, extra = 0;
        for (int a = 0; a < 256; a++) begin
            if (a <= upto) begin
                if (!wrote[a] || mem[a] != exp_val(a, b, l)) begin
                    if (a < b - 1) bad3++;
                    else if (a == b - 1) bad4++;
                    else if (a < l) bad5++;
                    else bad6++;
                end
            end else if (wrote[a]) extra++;
        end
        chk(bad3 == 0, "R3 linear entries", bad3, 0);
        chk(bad4 == 0, "R4 terminator entry", bad4, 0);
        chk(bad5 == 0, "R5 ring entries", bad5, 0);
        chk(bad6 == 0, "R6 closure entry", bad6, 0);
        chk(extra == 0, "R7 no stray writes", extra, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk(!busy_o && !done_o && !err_o && !cmd_wr_o, "R12 reset outputs",
            {busy_o, done_o, err_o, cmd_wr_o}, 0);
        rst_n = 1'b1;

        foreach (VECS[k]) begin
            vec_t v = VECS[k];
            int b = int'(v.b), l = int'(v.l), f = int'(v.fail);
            lat_norm = int'(v.lat);
            lat_fail = int'(v.lim) + 1;
            fail_at  = f;
            kick(b, l, int'(v.lim));
            chk(busy_o, "R10 busy after start", busy_o, 1);
            wait_end();
            @(negedge clk);
            chk(op_err == 0, "R1 write opcode", op_err, 0);
            chk(overlap_err == 0, "R2 one outstanding", overlap_err, 0);
            chk(order_err == 0, "R7 ascending order", order_err, 0);
            chk(n_twice == 0, "R7 written once", n_twice, 0);
            if (f == NONE) begin
                // R8: completion, including latency equal to the limit
                chk(done_o && !err_o, "R8 run completes", {done_o, err_o}, 2);
                chk(n_iss == l + 1, "R7 write count", n_iss, l + 1);
                check_table(b, l, l);
                repeat (5) @(negedge clk);
                chk(done_o && !busy_o, "R10 done held", done_o, 1);
            end else begin
                chk(err_o && !done_o, "R9 abort flag", {done_o, err_o}, 1);
                chk(int'(err_addr_o) == f, "R9 fail address", err_addr_o, f);
                chk(int'(err_phase_o) == exp_phase(f, b, l), "R9 fail phase",
                    err_phase_o, exp_phase(f, b, l));
                repeat (lat_fail + 8) @(negedge clk);
                chk(n_iss == f + 1, "R9 no writes after abort", n_iss, f + 1);
                check_table(b, l, f);
            end
        end

        // R11: start while busy is ignored
        fail_at = NONE; lat_norm = 2;
        kick(6, 20, 4);
        repeat (7) @(negedge clk);
        boundary_i = 8'd2; last_i = 8'd9; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R11 still busy", busy_o, 1);
        wait_end();
        @(negedge clk);
        chk(done_o && n_iss == 21, "R11 original run count", n_iss, 21);
        check_table(6, 20, 20);

        // R8: poll limit zero always times out at address 0, linear region
        kick(3, 5, 0);
        wait_end();
        @(negedge clk);
        chk(err_o && err_addr_o == 8'd0, "R8 zero limit abort", err_addr_o, 0);
        repeat (10) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end
endmodule